// File: doc/BRIEF.md
# Odd-Step Decimal Down Counter with Seven-Segment Output

This block is a synchronous down counter that walks a fixed, uneven sequence of decimal values and drives one seven-segment digit. Between 9 and 1 it moves down by two, so it only lands on odd values. From 1 it drops to 0, which is shown even though it is not odd, and from 0 it returns to 9. Each of these jumps happens on a single clock edge. The counter decodes the value it currently holds and steers the next-state logic straight to the successor. It never passes through a value outside the sequence and never needs an asynchronous correction.

A mode input picks the starting point of the first pass when the counter leaves reset. With mode low it starts at 9. With mode high it starts at 5, runs 5, 3, 1, 0, and from there repeats full passes from 9. An enable input gates every step. The present value is available as a 4-bit BCD code, and the matching segment pattern is decoded from it.

Top module: `odd_down_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads 9 if `mode` is 0 and 5 if `mode` is 1. The value shows on `bcd` after that edge.
- R2: With `rst` low and `en` high, each rising edge moves `bcd` along 9 → 7 → 5 → 3 → 1 → 0.
- R3: From 0, one enabled edge takes `bcd` directly to 9. No other value appears between them.
- R4: With `rst` low and `en` low, `bcd` and `seg` keep their values across the edge.
- R5: `mode` has no effect while `rst` is low. Changing it during counting leaves the sequence on `bcd` and `seg` unchanged.
- R6: After a reset with `mode` at 1, enabled edges give 5, 3, 1, 0 and then 9, 7, 5, 3, 1, 0 repeated.
- R7: `seg` is active high with bit 6 = a down to bit 0 = g. The codes are 0 → 7'h7E, 1 → 7'h30, 3 → 7'h79, 5 → 7'h5B, 7 → 7'h70 and 9 → 7'h7B. `seg` changes in the same cycle as `bcd`.
- R8: Once out of reset, `bcd` only ever holds 0, 1, 3, 5, 7 or 9.
- R9: `rst` takes priority over `en`. A reset edge with `en` high still loads the start value from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Rising-edge clock |
| rst  | input  | 1 | Synchronous reset, active high |
| en   | input  | 1 | Step enable, active high |
| mode | input  | 1 | Start select sampled during reset: 0 → 9, 1 → 5 |
| bcd  | output | 4 | Present counter value in BCD |
| seg  | output | 7 | Segment lines a..g, bit 6 = a, active high |

## Verification
Each value of `rst`, `en` and `mode` is applied between two rising edges. Its result appears on `bcd` after exactly one rising edge, and `seg` follows in the same cycle through combinational decode. The bench applies its inputs on the falling edge. For each edge it queues one expected value, computed from the sequence list of the requirements. The monitor reads both outputs 5 ns after the following rising edge, so every queue entry lines up with the edge that produced it.

// File: rtl/odc_pkg.sv
package odc_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Segment lines, a in the MSB down to g in the LSB, active high.
    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
        logic e;
        logic f;
        logic g;
    } seg_t;

    // Control inputs as sampled at one edge.
    typedef struct packed {
        logic rst;
        logic en;
        logic mode;
    } ctl_t;

    // A value is part of the sequence if it is 0 or odd and not above the top.
    function automatic logic in_sequence(digit_t v, digit_t top);
        return (v == '0) || (v[0] && (v <= top));
    endfunction

    // Successor along the sequence. Terminal and odd-bottom states are decoded
    // directly, so each jump is one edge.
    function automatic digit_t successor(digit_t v, digit_t top);
        digit_t nx;
        if (!in_sequence(v, top))
            nx = top;
        else if (v == '0)
            nx = top;
        else if (v == digit_t'(1))
            nx = '0;
        else
            nx = v - digit_t'(2);
        return nx;
    endfunction

    function automatic seg_t encode_digit(digit_t v);
        seg_t s;
        unique case (v)
            digit_t'(0): s = 7'b1111110;
            digit_t'(1): s = 7'b0110000;
            digit_t'(3): s = 7'b1111001;
            digit_t'(5): s = 7'b1011011;
            digit_t'(7): s = 7'b1110000;
            digit_t'(9): s = 7'b1111011;
            default:     s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/odc_next.sv
module odc_next
    import odc_pkg::*;
#(
    parameter int TOP_VAL = 9,
    parameter int ALT_VAL = 5
) (
    input  ctl_t   ctl,
    input  digit_t cur,
    output digit_t nxt
);
    localparam digit_t TOP = digit_t'(TOP_VAL);
    localparam digit_t ALT = digit_t'(ALT_VAL);

    digit_t start_val;

    always_comb begin
        start_val = ctl.mode ? ALT : TOP;
        if (ctl.rst)
            nxt = start_val;
        else if (ctl.en)
            nxt = successor(cur, TOP);
        else
            nxt = cur;
    end
endmodule

// File: rtl/odc_state.sv
module odc_state
    import odc_pkg::*;
(
    input  logic   clk,
    input  digit_t nxt,
    output digit_t cur
);
    always_ff @(posedge clk) begin
        cur <= nxt;
    end
endmodule

// File: rtl/odc_seg.sv
module odc_seg
    import odc_pkg::*;
(
    input  digit_t            val,
    output logic [SEG_W-1:0]  seg
);
    seg_t pattern;

    always_comb begin
        pattern = encode_digit(val);
        seg     = pattern;
    end
endmodule

// File: rtl/odd_down_counter.sv
module odd_down_counter
    import odc_pkg::*;
#(
    parameter int TOP_VAL = 9,
    parameter int ALT_VAL = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode,
    output logic [DIGIT_W-1:0] bcd,
    output logic [SEG_W-1:0]   seg
);
    ctl_t   ctl;
    digit_t cur;
    digit_t nxt;

    always_comb begin
        ctl.rst  = rst;
        ctl.en   = en;
        ctl.mode = mode;
    end

    odc_next #(
        .TOP_VAL(TOP_VAL),
        .ALT_VAL(ALT_VAL)
    ) u_next (
        .ctl (ctl),
        .cur (cur),
        .nxt (nxt)
    );

    odc_state u_state (
        .clk (clk),
        .nxt (nxt),
        .cur (cur)
    );

    odc_seg u_seg (
        .val (cur),
        .seg (seg)
    );

    assign bcd = cur;
endmodule

// File: rtl/odc_checker.sv
module odc_checker
    import odc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               mode,
    input logic [DIGIT_W-1:0] bcd,
    input logic [SEG_W-1:0]   seg
);
    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bcd == ($past(mode) ? 4'd5 : 4'd9))); // R1

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (en && bcd > 4'd1) |=> ($past(bcd) - bcd == 4'd2)); // R2

    AST_ONE_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en && bcd == 4'd1) |=> (bcd == 4'd0)); // R2

    AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (en && bcd == 4'd0) |=> (bcd == 4'd9)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(bcd) && $stable(seg))); // R4

    AST_LEGAL_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (bcd == 4'd0 || (bcd[0] && bcd <= 4'd9))); // R8

    AST_SEG_LIT: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (seg != '0 && seg[6:4] != 3'b000 || seg == 7'h30)); // R7
endmodule

bind odd_down_counter odc_checker u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .mode (mode),
    .bcd  (bcd),
    .seg  (seg)
);

// File: tb/odd_down_counter_bench.sv
module odd_down_counter_bench;

    typedef struct {
        logic [3:0] bcd;
        logic [6:0] seg;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic       mode = 1'b0;
    logic [3:0] bcd;
    logic [6:0] seg;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   drv_done = 1'b0;

    // Sequence list from R2/R3; R6 starts at index 2 (value 5).
    int seq_list [6] = '{9, 7, 5, 3, 1, 0};
    int ref_idx = 0;

    always #10 clk = ~clk;

    odd_down_counter u_odd_down_counter (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .mode (mode),
        .bcd  (bcd),
        .seg  (seg)
    );

    // R7 segment codes.
    function automatic logic [6:0] seg_code(int v);
        case (v)
            0: return 7'h7E;
            1: return 7'h30;
            3: return 7'h79;
            5: return 7'h5B;
            7: return 7'h70;
            9: return 7'h7B;
            default: return 7'h00;
        endcase
    endfunction

    task automatic step(input logic r, input logic e, input logic m, input string req);
        exp_t item;
        @(negedge clk);
        rst  = r;
        en   = e;
        mode = m;
        if (r)
            ref_idx = m ? 2 : 0;
        else if (e)
            ref_idx = (ref_idx + 1) % 6;
        item.bcd = 4'(seq_list[ref_idx]);
        item.seg = seg_code(seq_list[ref_idx]);
        item.req = req;
        exp_q.push_back(item);
    endtask

    // Monitor: one comparison per rising edge, 5 ns after it.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                total++;
                if (bcd !== it.bcd) begin
                    bad++;
                    $display("FAIL %s bcd actual=%0d expected=%0d", it.req, bcd, it.bcd);
                end
                total++;
                if (seg !== it.seg) begin
                    bad++;
                    $display("FAIL R7 (%s) seg actual=%h expected=%h", it.req, seg, it.seg);
                end
            end
        end
    end

    initial begin
        // R1: reset with mode 0
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, "R1");
        // R2, R3, R8: two full passes from 9
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, "R3");
        // Advance to 5, then R4 idle hold
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, "R2");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R4");
        // R5: mode toggles while counting
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'(i % 2), "R5");
        step(1'b0, 1'b0, 1'b1, "R4");
        // R6: reset with mode 1, then through the wrap
        step(1'b1, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, "R6");
        // R9: reset with en high wins, both modes
        step(1'b1, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b0, "R2");
        step(1'b1, 1'b1, 1'b1, "R9");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, "R4");
        drv_done = 1'b1;
    end

    initial begin
        wait (drv_done && exp_q.size() == 0);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        bad++;
        $display("watchdog expired before the run completed");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule